// File: doc/BRIEF.md
# Multiport Word Memory with Priority Write Merge

This block is a storage array of 2**ABITS words, each WIDTH bits, with a configurable number of read ports and write ports. Every per-port signal sits side by side on a wide bus. Port i always occupies slice i: bits [i*ABITS +: ABITS] of an address bus, and bits [i*WIDTH +: WIDTH] of a data or bit-enable bus. Each read port is built, by parameter, either as a combinational lookup or as a registered port. A registered port is clocked on the rising or on the falling edge of `clk`.

All write ports share the rising edge of `clk`. Each write port writes only the bits whose enable is set. When two or more ports enable the same bit of the same word on one edge, that bit takes the data of the port with the largest priority value. If the priorities are equal, the port with the larger index wins. Reset loads the whole array from the INIT parameter and clears the registered read outputs.

With the default parameters there are three read ports: port 0 is registered on the rising edge, port 1 is registered on the falling edge, and port 2 is combinational. There are three write ports with priorities 2, 5 and 5. The array holds eight bytes, and INIT sets word k to 0xA0+k.

Top module: `mpmem_array`

## Requirements
- R1: While `rst_n` is low, word k of the array is set from INIT bits [k*WIDTH +: WIDTH] and every registered read output is set to zero.
- R2: Read port i uses bits [i*ABITS +: ABITS] of `rd_addr` and bits [i*WIDTH +: WIDTH] of `rd_data`. Write port j uses the slice j of `wr_addr`, `wr_data` and `wr_be` in the same way. Ports that address different words do not disturb each other.
- R3: On a rising edge, a write port changes only those bits of its addressed word whose `wr_be` bit is 1. All other bits of that word keep their value.
- R4: A bit enabled by several write ports on one edge takes the data of the port with the largest WR_PRIO value. That value is the 32-bit field j of WR_PRIO.
- R5: Among conflicting ports with equal priority, the port with the larger index wins the bit.
- R6: A bit enabled by exactly one write port takes that port's data, whatever the priorities of the other ports writing the same word.
- R7: A read port registered on the rising edge loads the addressed word on a rising edge when its `rd_en` bit is 1, and holds its output when that bit is 0.
- R8: A read port with RD_RISE bit 0 samples on the falling edge of `clk`, and holds its output when its enable is 0.
- R9: A registered read of a word that is written on the same edge returns the contents from before the write.
- R10: A combinational read port (RD_CLKED bit 0) shows the addressed word without waiting for a clock edge, and its `rd_en` bit has no effect.
- R11: When every `wr_be` bit is 0, the contents of the array do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for writes and for the registered read ports |
| rst_n | input | 1 | Active-low asynchronous reset; loads INIT into the array |
| rd_en | input | RD_PORTS | Read enable, one bit per read port |
| rd_addr | input | RD_PORTS*ABITS | Packed read addresses |
| rd_data | output | RD_PORTS*WIDTH | Packed read data |
| wr_addr | input | WR_PORTS*ABITS | Packed write addresses |
| wr_data | input | WR_PORTS*WIDTH | Packed write data |
| wr_be | input | WR_PORTS*WIDTH | Packed per-bit write enables |

## Verification
A write that is presented in cycle c lands on the next rising edge. The combinational port shows it right after that edge. A rising-edge read that is issued in cycle c appears after the next rising edge. A falling-edge read samples the array in the middle of cycle c and is compared after the following rising edge. The driver drives the inputs just after a rising edge. For each result it queues the cycle number in which that result is due. The monitor samples 1 ns after each rising edge and compares only the items due in that cycle, so every check falls after the registers it depends on have updated.

// File: rtl/mpmem_pkg.sv
package mpmem_pkg;

    // Width of one packed priority field in WR_PRIO.
    localparam int PRIO_BITS = 32;

    typedef logic [PRIO_BITS-1:0] prio_t;

    // Read port build variants.
    typedef enum logic [1:0] {
        RD_COMB  = 2'd0,
        RD_RISE  = 2'd1,
        RD_FALL  = 2'd2
    } rd_kind_e;

endpackage

// File: rtl/mpmem_word_merge.sv
// Next-state logic for one stored word: resolves every write port bit by bit.
module mpmem_word_merge
    import mpmem_pkg::*;
#(
    parameter int                          ABITS    = 3,
    parameter int                          WIDTH    = 8,
    parameter int                          WR_PORTS = 3,
    parameter logic [WR_PORTS*PRIO_BITS-1:0] WR_PRIO = '0,
    parameter int                          WORD_IDX = 0
) (
    input  logic [WIDTH-1:0]          cur_word,
    input  logic [WR_PORTS*ABITS-1:0] wr_addr,
    input  logic [WR_PORTS*WIDTH-1:0] wr_data,
    input  logic [WR_PORTS*WIDTH-1:0] wr_be,
    output logic [WIDTH-1:0]          nxt_word
);

    localparam logic [ABITS-1:0] MY_ADDR = ABITS'(WORD_IDX);

    logic [WR_PORTS-1:0] port_hit;

    // Which write ports address this word.
    genvar gj;
    generate
        for (gj = 0; gj < WR_PORTS; gj++) begin : g_hit
            assign port_hit[gj] = (wr_addr[gj*ABITS +: ABITS] == MY_ADDR);
        end
    endgenerate

    // For each bit, scan the ports in rising index order. A port takes the
    // bit when its priority is not lower than the best seen so far, so on
    // equal priority the later (higher index) port wins.
    always_comb begin
        nxt_word = cur_word;
        for (int b = 0; b < WIDTH; b++) begin
            logic  taken;
            prio_t best;
            taken = 1'b0;
            best  = '0;
            for (int j = 0; j < WR_PORTS; j++) begin
                if (port_hit[j] && wr_be[j*WIDTH + b]) begin
                    if (!taken || (WR_PRIO[j*PRIO_BITS +: PRIO_BITS] >= best)) begin
                        nxt_word[b] = wr_data[j*WIDTH + b];
                        best        = WR_PRIO[j*PRIO_BITS +: PRIO_BITS];
                        taken       = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/mpmem_rd_port.sv
// One read port; CLKED/RISE pick combinational, rising-edge or falling-edge form.
module mpmem_rd_port
    import mpmem_pkg::*;
#(
    parameter int ABITS = 3,
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    parameter bit CLKED = 1'b1,
    parameter bit RISE  = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic [ABITS-1:0]       addr,
    input  logic [DEPTH*WIDTH-1:0] mem_flat,
    output logic [WIDTH-1:0]       data
);

    localparam rd_kind_e KIND = !CLKED ? RD_COMB : (RISE ? RD_RISE : RD_FALL);

    logic [WIDTH-1:0] words [DEPTH];
    logic [WIDTH-1:0] sel_word;

    genvar gw;
    generate
        for (gw = 0; gw < DEPTH; gw++) begin : g_unpack
            assign words[gw] = mem_flat[gw*WIDTH +: WIDTH];
        end
    endgenerate

    assign sel_word = words[addr];

    generate
        if (KIND == RD_COMB) begin : g_comb
            logic unused_inputs;
            assign unused_inputs = ^{clk, rst_n, en};
            assign data = sel_word;
        end else if (KIND == RD_RISE) begin : g_rise
            logic [WIDTH-1:0] data_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)  data_q <= '0;
                else if (en) data_q <= sel_word;
            end
            assign data = data_q;
        end else begin : g_fall
            logic [WIDTH-1:0] data_q;
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n)  data_q <= '0;
                else if (en) data_q <= sel_word;
            end
            assign data = data_q;
        end
    endgenerate

endmodule

// File: rtl/mpmem_array.sv
// Top: storage array, per-word write merge, per-port read logic.
module mpmem_array
    import mpmem_pkg::*;
#(
    parameter int                              ABITS    = 3,
    parameter int                              WIDTH    = 8,
    parameter int                              RD_PORTS = 3,
    parameter int                              WR_PORTS = 3,
    parameter logic [RD_PORTS-1:0]             RD_CLKED = 3'b011,
    parameter logic [RD_PORTS-1:0]             RD_RISE  = 3'b101,
    parameter logic [WR_PORTS*PRIO_BITS-1:0]   WR_PRIO  = {32'd5, 32'd5, 32'd2},
    parameter logic [(2**ABITS)*WIDTH-1:0]     INIT     = 64'hA7A6_A5A4_A3A2_A1A0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [RD_PORTS-1:0]       rd_en,
    input  logic [RD_PORTS*ABITS-1:0] rd_addr,
    output logic [RD_PORTS*WIDTH-1:0] rd_data,
    input  logic [WR_PORTS*ABITS-1:0] wr_addr,
    input  logic [WR_PORTS*WIDTH-1:0] wr_data,
    input  logic [WR_PORTS*WIDTH-1:0] wr_be
);

    localparam int DEPTH = 2 ** ABITS;
    localparam int BITS  = DEPTH * WIDTH;

    logic [BITS-1:0] mem_q;
    logic [BITS-1:0] mem_d;

    // Write side: one merge unit per word.
    genvar gw;
    generate
        for (gw = 0; gw < DEPTH; gw++) begin : g_word
            mpmem_word_merge #(
                .ABITS    (ABITS),
                .WIDTH    (WIDTH),
                .WR_PORTS (WR_PORTS),
                .WR_PRIO  (WR_PRIO),
                .WORD_IDX (gw)
            ) u_merge (
                .cur_word (mem_q[gw*WIDTH +: WIDTH]),
                .wr_addr  (wr_addr),
                .wr_data  (wr_data),
                .wr_be    (wr_be),
                .nxt_word (mem_d[gw*WIDTH +: WIDTH])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= INIT;
        else        mem_q <= mem_d;
    end

    // Read side: one port instance per slice.
    genvar gr;
    generate
        for (gr = 0; gr < RD_PORTS; gr++) begin : g_rd
            mpmem_rd_port #(
                .ABITS (ABITS),
                .WIDTH (WIDTH),
                .DEPTH (DEPTH),
                .CLKED (RD_CLKED[gr]),
                .RISE  (RD_RISE[gr])
            ) u_port (
                .clk      (clk),
                .rst_n    (rst_n),
                .en       (rd_en[gr]),
                .addr     (rd_addr[gr*ABITS +: ABITS]),
                .mem_flat (mem_q),
                .data     (rd_data[gr*WIDTH +: WIDTH])
            );
        end
    endgenerate

endmodule

// File: rtl/mpmem_array_chk.sv
module mpmem_array_chk
    import mpmem_pkg::*;
#(
    parameter int                  ABITS    = 3,
    parameter int                  WIDTH    = 8,
    parameter int                  RD_PORTS = 3,
    parameter int                  WR_PORTS = 3,
    parameter logic [RD_PORTS-1:0] RD_CLKED = 3'b011,
    parameter logic [RD_PORTS-1:0] RD_RISE  = 3'b101
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [RD_PORTS-1:0]           rd_en,
    input logic [RD_PORTS*ABITS-1:0]     rd_addr,
    input logic [RD_PORTS*WIDTH-1:0]     rd_data,
    input logic [WR_PORTS*ABITS-1:0]     wr_addr,
    input logic [WR_PORTS*WIDTH-1:0]     wr_data,
    input logic [WR_PORTS*WIDTH-1:0]     wr_be,
    input logic [(2**ABITS)*WIDTH-1:0]   mem_q
);

    // Record a write made by port 0 alone, to check it one edge later.
    logic             solo_q;
    logic [ABITS-1:0] solo_addr_q;
    logic [WIDTH-1:0] solo_data_q;
    logic [WIDTH-1:0] solo_be_q;
    logic [WIDTH-1:0] solo_old_q;
    logic             solo_now;

    assign solo_now = ((wr_be >> WIDTH) == '0) && (wr_be[WIDTH-1:0] != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            solo_q      <= 1'b0;
            solo_addr_q <= '0;
            solo_data_q <= '0;
            solo_be_q   <= '0;
            solo_old_q  <= '0;
        end else begin
            solo_q      <= solo_now;
            solo_addr_q <= wr_addr[ABITS-1:0];
            solo_data_q <= wr_data[WIDTH-1:0];
            solo_be_q   <= wr_be[WIDTH-1:0];
            solo_old_q  <= mem_q[wr_addr[ABITS-1:0]*WIDTH +: WIDTH];
        end
    end

    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_be == '0) |=> $stable(mem_q)); // R11

    AST_ENABLED_BITS_LAND: assert property (@(posedge clk) disable iff (!rst_n)
        solo_q |-> ((mem_q[solo_addr_q*WIDTH +: WIDTH] & solo_be_q) == (solo_data_q & solo_be_q))); // R3

    AST_MASKED_BITS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        solo_q |-> ((mem_q[solo_addr_q*WIDTH +: WIDTH] & ~solo_be_q) == (solo_old_q & ~solo_be_q))); // R3

    genvar gi;
    generate
        for (gi = 0; gi < RD_PORTS; gi++) begin : g_chk
            logic [WIDTH-1:0] cur_word;
            logic [WIDTH-1:0] port_out;
            assign cur_word = mem_q[rd_addr[gi*ABITS +: ABITS]*WIDTH +: WIDTH];
            assign port_out = rd_data[gi*WIDTH +: WIDTH];

            if (!RD_CLKED[gi]) begin : g_comb
                AST_COMB_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
                    rd_en[gi] || !rd_en[gi] |-> (port_out == cur_word)); // R10
            end else if (RD_RISE[gi]) begin : g_rise
                AST_RISE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                    !rd_en[gi] |=> $stable(port_out)); // R7
                AST_RISE_OLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
                    rd_en[gi] |=> (port_out == $past(cur_word))); // R9
            end else begin : g_fall
                AST_FALL_HOLD: assert property (@(negedge clk) disable iff (!rst_n)
                    !rd_en[gi] |=> $stable(port_out)); // R8
            end
        end
    endgenerate

endmodule

bind mpmem_array mpmem_array_chk #(
    .ABITS    (ABITS),
    .WIDTH    (WIDTH),
    .RD_PORTS (RD_PORTS),
    .WR_PORTS (WR_PORTS),
    .RD_CLKED (RD_CLKED),
    .RD_RISE  (RD_RISE)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wr_be   (wr_be),
    .mem_q   (mem_q)
);

// File: tb/mpmem_array_test.sv
`timescale 1ns/1ps
module mpmem_array_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  rd_en = '0;
    logic [8:0]  rd_addr = '0;
    logic [23:0] rd_data;
    logic [8:0]  wr_addr = '0;
    logic [23:0] wr_data = '0;
    logic [23:0] wr_be = '0;

    always #10 clk = ~clk;

    mpmem_array uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_be   (wr_be)
    );

    typedef struct {
        int         req;
        int         port;
        logic [7:0] exp;
        int         due;
    } item_t;

    item_t q[$];
    int    cyc   = 0;
    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic push(input int req, input int port, input logic [7:0] exp, input int due);
        item_t it;
        it.req = req; it.port = port; it.exp = exp; it.due = due;
        q.push_back(it);
    endtask

    task automatic set_rd(input int p, input logic en, input logic [2:0] a);
        rd_en[p] = en;
        rd_addr[p*3 +: 3] = a;
    endtask

    task automatic set_wr(input int p, input logic [2:0] a, input logic [7:0] d, input logic [7:0] be);
        wr_addr[p*3 +: 3] = a;
        wr_data[p*8 +: 8] = d;
        wr_be[p*8 +: 8]   = be;
    endtask

    // Monitor: 1 ns after each rising edge, compare every item due now.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            while (q.size() > 0 && q[0].due <= cyc) begin
                item_t it;
                logic [7:0] got;
                it  = q.pop_front();
                got = rd_data[it.port*8 +: 8];
                total++;
                if (got !== it.exp || it.due != cyc) begin
                    bad++;
                    $display("FAIL R%0d port %0d cycle %0d: got %h expected %h",
                             it.req, it.port, cyc, got, it.exp);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        // R1: reset state. Registered outputs are zero; async port shows INIT word 5.
        set_rd(2, 1'b0, 3'd5);
        push(1, 0, 8'h00, cyc + 1);
        push(1, 1, 8'h00, cyc + 1);
        push(1, 2, 8'hA5, cyc + 1);
        tick();
        // R7 rising read, R8 falling read, R10 async read.
        set_rd(0, 1'b1, 3'd3);
        set_rd(1, 1'b1, 3'd6);
        set_rd(2, 1'b1, 3'd7);
        push(7, 0, 8'hA3, cyc + 1);
        push(8, 1, 8'hA6, cyc + 1);
        push(10, 2, 8'hA7, cyc + 1);
        tick();
        // R7/R8 hold with enable low; R10 async ignores enable.
        set_rd(0, 1'b0, 3'd1);
        set_rd(1, 1'b0, 3'd2);
        set_rd(2, 1'b0, 3'd2);
        push(7, 0, 8'hA3, cyc + 1);
        push(8, 1, 8'hA6, cyc + 1);
        push(10, 2, 8'hA2, cyc + 1);
        tick();
        // R3 partial write to word 4; R9 same-edge read gives old data.
        set_wr(0, 3'd4, 8'hFF, 8'h0F);
        set_rd(0, 1'b1, 3'd4);
        set_rd(1, 1'b1, 3'd4);
        set_rd(2, 1'b0, 3'd4);
        push(9, 0, 8'hA4, cyc + 1);
        push(8, 1, 8'hA4, cyc + 1);
        push(3, 2, 8'hAF, cyc + 1);
        tick();
        // R3 written word read back; R11 idle write keeps contents.
        set_wr(0, 3'd0, 8'h00, 8'h00);
        push(3, 0, 8'hAF, cyc + 1);
        push(8, 1, 8'hAF, cyc + 1);
        push(11, 2, 8'hAF, cyc + 1);
        tick();
        // R4 / R6: port 1 (prio 5) beats port 0 (prio 2) on upper nibble,
        // lower nibble enabled only by port 0.
        set_rd(0, 1'b0, 3'd1);
        set_rd(1, 1'b0, 3'd1);
        set_rd(2, 1'b0, 3'd1);
        set_wr(0, 3'd1, 8'h00, 8'hFF);
        set_wr(1, 3'd1, 8'hFF, 8'hF0);
        push(4, 2, 8'hF0, cyc + 1);
        tick();
        // R5: ports 1 and 2 tie at prio 5, index 2 wins lower nibble;
        // upper nibble port 1 beats port 0. R9 read of word 2 gives old data.
        set_wr(0, 3'd2, 8'h55, 8'hFF);
        set_wr(1, 3'd2, 8'h33, 8'hFF);
        set_wr(2, 3'd2, 8'hCC, 8'h0F);
        set_rd(0, 1'b1, 3'd2);
        set_rd(2, 1'b0, 3'd2);
        push(9, 0, 8'hA2, cyc + 1);
        push(5, 2, 8'h3C, cyc + 1);
        tick();
        // Read back results; R11 untouched word 0 still holds INIT.
        set_wr(0, 3'd0, 8'h00, 8'h00);
        set_wr(1, 3'd0, 8'h00, 8'h00);
        set_wr(2, 3'd0, 8'h00, 8'h00);
        set_rd(0, 1'b1, 3'd1);
        set_rd(1, 1'b1, 3'd2);
        set_rd(2, 1'b0, 3'd0);
        push(4, 0, 8'hF0, cyc + 1);
        push(5, 1, 8'h3C, cyc + 1);
        push(11, 2, 8'hA0, cyc + 1);
        tick();
        // R2: two write ports, different words, same edge.
        set_rd(0, 1'b0, 3'd0);
        set_rd(1, 1'b0, 3'd0);
        set_wr(0, 3'd5, 8'h11, 8'hFF);
        set_wr(2, 3'd6, 8'h22, 8'hFF);
        tick();
        set_wr(0, 3'd0, 8'h00, 8'h00);
        set_wr(2, 3'd0, 8'h00, 8'h00);
        set_rd(0, 1'b1, 3'd5);
        set_rd(1, 1'b1, 3'd6);
        set_rd(2, 1'b0, 3'd6);
        push(2, 0, 8'h11, cyc + 1);
        push(2, 1, 8'h22, cyc + 1);
        push(2, 2, 8'h22, cyc + 1);
        tick();
        repeat (3) tick();
        if (q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL scoreboard: got %0d pending expected 0", q.size());
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule